// File: doc/BRIEF.md
# Multicycle byte-CPU control sequencer

This block is the control sequencer of a small multicycle processor, with a simple datapath built in. One memory holds both code and data: it has 64 byte locations and a 6-bit address. The processor keeps eight 8-bit registers. R7 is the program counter and R6 is the link register. Each 16-bit instruction takes two byte reads. The low byte comes from the address in the program counter and the high byte from the next address. The sequencer then moves through decode and execute. Loads, stores and the indirect branch also pass through a memory state, and loads and the indirect branch add a write-back state after that.

The memory sits outside the block. The block drives a byte address, read and write enables and write data, and it reads the memory's combinational read data in the same cycle. The program counter, the zero and carry flags, and a pulse in the last cycle of each instruction are brought out for observation.

Top module: `bytecpu_seq`

## Requirements
- R1: While reset is asserted, the program counter reads 0, both flags read 0 and no memory write is issued.
- R2: Each instruction starts by reading the low byte at PC[5:0] and then the high byte at PC[5:0]+1. PC rises by 2 after the second read. A register or immediate ALU instruction takes four cycles, and `instr_done` is high in the fourth.
- R3: Bits 15:14 = 00 select arithmetic, with the command in bits 13:12 (0 ADD, 1 SUB, 3 MOV). With bit 11 clear, the instruction computes Rd(10:8) = Rn(7:5) op Rm(2:0). With bit 11 set, it computes Rd = Rd op imm. Here imm is imm5 (bits 4:0), zero-extended and rotated left by bits 7:5. MOV writes imm.
- R4: ADD, SUB and CMP (command 2) set Z when the 8-bit result is zero. ADD sets C to the carry out. SUB and CMP set C to "no borrow". CMP writes no register. No other instruction changes the flags.
- R5: Bits 15:14 = 01 with command bits 13:11 = 0, 1 or 2 give Rd = Rn AND, OR or XOR Rm.
- R6: Commands 3 to 7 in the 01 group (ROL, ROR, LSL, LSR, ASR) shift or rotate Rd in place. The amount is bits 2:0. ASR fills with the sign bit.
- R7: Bits 15:14 = 10 with bit 13 clear is a store. It writes Rd in exactly one cycle, and that cycle ends the instruction. With bit 12 set, the address is {H(bit 11), bits 4:0}. With bit 12 clear, the address is Rn + {H, bits 4:0}, taken modulo 64.
- R8: Bit 13 set in the 10 group is a load. It uses the same address forms as a store and writes the byte read into Rd.
- R9: Bits 15:14 = 11 are branches, with the type in bits 13:12. Type 00 writes addr6 (bits 5:0), zero-extended, into R7. Type 01 does the same after copying the already-advanced R7 into R6.
- R10: Type 10 loads R7 with the byte stored at memory[addr6].
- R11: Type 11 branches only when condition bits 11:10 hold: 00 Z set, 01 Z clear, 10 C set, 11 C clear. Otherwise execution continues at the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 8 | Combinational read data from the shared memory |
| mem_addr | output | 6 | Byte address for the current memory access |
| mem_wdata | output | 8 | Store data |
| mem_re | output | 1 | Memory read in this cycle |
| mem_we | output | 1 | Memory write in this cycle |
| pc_o | output | 8 | Current value of R7 |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| instr_done | output | 1 | High in the final cycle of each instruction |

## Verification
The bench aims at the rotate corners: an immediate rotated past bit 7, a right rotate that wraps bits into the top, and an arithmetic shift of a negative value. A design that rotated the wrong way or shifted zeros in would store the wrong byte. A register-offset store is placed so that its address wraps past 63. An unmasked adder would write to the wrong location, and the scoreboard flags that as a mismatch. Each branch condition is tried both taken and not taken, with a trap store on every wrong path. An inverted condition therefore produces an unexpected write. The link value, the indirect target and a stored R7 all catch a program counter that is advanced too early, too late or by the wrong amount.

// File: rtl/bytecpu_seq.sv
module bytecpu_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] mem_rdata,
  output logic [5:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_re,
  output logic       mem_we,
  output logic [7:0] pc_o,
  output logic       zf_o,
  output logic       cf_o,
  output logic       instr_done
);
  typedef enum logic [2:0] {S_FLO, S_FHI, S_DEC, S_EXE, S_MEM, S_WB} st_t;

  st_t         st;
  logic [7:0]  rf [8];
  logic [15:0] ir;
  logic [7:0]  opa, opb, mdr;
  logic [5:0]  ea;
  logic        zf, cf;

  logic [1:0] op, acmd, btype, cond;
  logic [2:0] rd, rn, rm, lcmd, sh;
  logic [7:0] immx, imm_rot;
  assign op    = ir[15:14];
  assign acmd  = ir[13:12];
  assign lcmd  = ir[13:11];
  assign btype = ir[13:12];
  assign cond  = ir[11:10];
  assign rd    = ir[10:8];
  assign rn    = ir[7:5];
  assign rm    = ir[2:0];
  assign immx  = {3'b000, ir[4:0]};
  assign imm_rot = (immx << ir[7:5]) | (immx >> (4'd8 - {1'b0, ir[7:5]}));

  logic is_load, is_store, is_bi, needs_mem;
  assign is_load   = (op == 2'b10) &&  ir[13];
  assign is_store  = (op == 2'b10) && !ir[13];
  assign is_bi     = (op == 2'b11) && (btype == 2'b10);
  assign needs_mem = (op == 2'b10) || is_bi;

  logic [7:0] a_sel, b_sel;
  always_comb begin
    a_sel = rf[rn];
    b_sel = rf[rm];
    case (op)
      2'b00: if (ir[11]) begin
        a_sel = rf[rd];
        b_sel = imm_rot;
      end
      2'b01: if (lcmd >= 3'd3) begin
        a_sel = rf[rd];
        b_sel = {5'b00000, ir[2:0]};
      end
      2'b10: b_sel = {2'b00, ir[11], ir[4:0]};
      default: ;
    endcase
  end

  logic [8:0] sum9, dif9;
  logic [7:0] rol_v, ror_v, asr_v, alu_res;
  logic       alu_c;
  assign sh    = opb[2:0];
  assign sum9  = {1'b0, opa} + {1'b0, opb};
  assign dif9  = {1'b0, opa} - {1'b0, opb};
  assign rol_v = (opa << sh) | (opa >> (4'd8 - {1'b0, sh}));
  assign ror_v = (opa >> sh) | (opa << (4'd8 - {1'b0, sh}));
  assign asr_v = $signed(opa) >>> sh;

  always_comb begin
    alu_res = opb;
    alu_c   = 1'b0;
    if (!op[0]) begin
      case (acmd)
        2'd0:       {alu_c, alu_res} = sum9;
        2'd1, 2'd2: begin alu_res = dif9[7:0]; alu_c = ~dif9[8]; end
        default:    alu_res = opb;
      endcase
    end else begin
      case (lcmd)
        3'd0: alu_res = opa & opb;
        3'd1: alu_res = opa | opb;
        3'd2: alu_res = opa ^ opb;
        3'd3: alu_res = rol_v;
        3'd4: alu_res = ror_v;
        3'd5: alu_res = opa << sh;
        3'd6: alu_res = opa >> sh;
        default: alu_res = asr_v;
      endcase
    end
  end

  logic wr_alu, wr_flags, cond_ok, br_take;
  assign wr_alu   = (op == 2'b01) || (op == 2'b00 && acmd != 2'd2);
  assign wr_flags = (op == 2'b00) && (acmd != 2'd3);
  always_comb begin
    case (cond)
      2'd0:    cond_ok = zf;
      2'd1:    cond_ok = !zf;
      2'd2:    cond_ok = cf;
      default: cond_ok = !cf;
    endcase
  end
  assign br_take = (op == 2'b11) &&
                   (btype == 2'b00 || btype == 2'b01 || (btype == 2'b11 && cond_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FLO;
      ir  <= '0;
      opa <= '0;
      opb <= '0;
      mdr <= '0;
      ea  <= '0;
      zf  <= 1'b0;
      cf  <= 1'b0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FLO: begin
          ir[7:0] <= mem_rdata;
          st      <= S_FHI;
        end
        S_FHI: begin
          ir[15:8] <= mem_rdata;
          rf[7]    <= rf[7] + 8'd2;
          st       <= S_DEC;
        end
        S_DEC: begin
          opa <= a_sel;
          opb <= b_sel;
          st  <= S_EXE;
        end
        S_EXE: begin
          st <= needs_mem ? S_MEM : S_FLO;
          if (op == 2'b10) ea <= ir[12] ? {ir[11], ir[4:0]} : opa[5:0] + opb[5:0];
          else             ea <= ir[5:0];
          if (wr_alu) rf[rd] <= alu_res;
          if (wr_flags) begin
            zf <= (alu_res == 8'd0);
            cf <= alu_c;
          end
          if (op == 2'b11 && btype == 2'b01) rf[6] <= rf[7];
          if (br_take) rf[7] <= {2'b00, ir[5:0]};
        end
        S_MEM: begin
          mdr <= mem_rdata;
          st  <= is_store ? S_FLO : S_WB;
        end
        S_WB: begin
          rf[is_bi ? 3'd7 : rd] <= mdr;
          st <= S_FLO;
        end
        default: st <= S_FLO;
      endcase
    end
  end

  assign mem_addr   = (st == S_FLO) ? rf[7][5:0] :
                      (st == S_FHI) ? rf[7][5:0] + 6'd1 : ea;
  assign mem_re     = (st == S_FLO) || (st == S_FHI) ||
                      (st == S_MEM && (is_load || is_bi));
  assign mem_we     = (st == S_MEM) && is_store;
  assign mem_wdata  = rf[rd];
  assign pc_o       = rf[7];
  assign zf_o       = zf;
  assign cf_o       = cf;
  assign instr_done = (st == S_EXE && !needs_mem) || (st == S_MEM && is_store) || (st == S_WB);
endmodule

// File: rtl/bytecpu_seq_chk.sv
module bytecpu_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] mem_addr,
  input logic       mem_re,
  input logic       mem_we,
  input logic [7:0] pc_o,
  input logic       zf_o,
  input logic       cf_o,
  input logic       instr_done
);
  // R7
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we));
  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);
  // R7
  write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> instr_done);
  // R2
  refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (mem_re && mem_addr == pc_o[5:0]));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> ##2 (pc_o == $past(pc_o, 2) + 8'd2));
  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable({zf_o, cf_o}));
endmodule

bind bytecpu_seq bytecpu_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
  .pc_o(pc_o), .zf_o(zf_o), .cf_o(cf_o), .instr_done(instr_done)
);

// File: tb/bytecpu_seq_test.sv
`timescale 1ns/1ps
module bytecpu_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mem_rdata, mem_wdata, pc_o;
  logic [5:0] mem_addr;
  logic       mem_re, mem_we, zf_o, cf_o, instr_done;

  always #5 clk = ~clk;

  bytecpu_seq uut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_we(mem_we), .pc_o(pc_o),
    .zf_o(zf_o), .cf_o(cf_o), .instr_done(instr_done)
  );

  logic [7:0] prog [64];
  logic [7:0] mem  [64];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (!rst_n) mem <= prog;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [5:0] a, input logic [7:0] d, input string req);
    exp_q.push_back({a, d});
    tag_q.push_back(req);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 8'h00;
  endtask

  task automatic put(input int k, input logic [15:0] w);
    prog[2*k]   = w[7:0];
    prog[2*k+1] = w[15:8];
  endtask

  function automatic logic [15:0] ai(input logic [1:0] c, input logic [2:0] d, input logic [2:0] rot, input logic [4:0] im);
    return {2'b00, c, 1'b1, d, rot, im};
  endfunction
  function automatic logic [15:0] ar(input logic [1:0] c, input logic [2:0] d, input logic [2:0] n, input logic [2:0] m);
    return {2'b00, c, 1'b0, d, n, 2'b00, m};
  endfunction
  function automatic logic [15:0] lr(input logic [2:0] c, input logic [2:0] d, input logic [2:0] n, input logic [2:0] m);
    return {2'b01, c, d, n, 2'b00, m};
  endfunction
  function automatic logic [15:0] ls(input logic [2:0] c, input logic [2:0] d, input logic [2:0] s);
    return {2'b01, c, d, 3'b000, 2'b00, s};
  endfunction
  function automatic logic [15:0] mi(input logic l, input logic [2:0] d, input logic [5:0] a);
    return {2'b10, l, 1'b1, a[5], d, 3'b000, a[4:0]};
  endfunction
  function automatic logic [15:0] mr(input logic l, input logic [2:0] d, input logic [2:0] n, input logic [5:0] o);
    return {2'b10, l, 1'b0, o[5], d, n, o[4:0]};
  endfunction
  function automatic logic [15:0] br(input logic [1:0] t, input logic [1:0] c, input logic [5:0] a);
    return {2'b11, t, c, 4'b0000, a};
  endfunction

  // monitor: pops the scoreboard on every write cycle
  initial begin
    logic [13:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && mem_we === 1'b1) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R11 unexpected write (wrong path or extra store): actual %0h expected none",
                   {mem_addr, mem_wdata});
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({mem_addr, mem_wdata} == e, t, "store addr/data", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic run_prog(input int ncyc);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R1
    chk(pc_o == 8'd0 && !zf_o && !cf_o && !mem_we, "R1", "reset state", {pc_o, zf_o, cf_o, mem_we}, 0);
    rst_n = 1'b1;
    // R2
    chk(mem_re && mem_addr == 6'd0, "R2", "low byte fetch address", mem_addr, 0);
    @(negedge clk);
    chk(mem_re && mem_addr == 6'd1, "R2", "high byte fetch address", mem_addr, 1);
    @(negedge clk);
    chk(pc_o == 8'd2, "R2", "pc after fetch", pc_o, 2);
    @(negedge clk);
    chk(instr_done, "R2", "ALU op done in 4th cycle", instr_done, 1);
    @(negedge clk);
    chk(mem_re && mem_addr == 6'd2, "R2", "next fetch address", mem_addr, 2);
    repeat (ncyc) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "stores still pending", exp_q.size(), 0);
  endtask

  bit done = 0;

  initial begin
    rst_n = 1'b0;
    // program A: arithmetic and logic
    clear_prog();
    put(0,  ai(2'd3, 3'd0, 3'd0, 5'd5));       // MOV R0,#5
    put(1,  ai(2'd3, 3'd1, 3'd2, 5'd20));      // MOV R1,#20 rot2 = 0x50
    put(2,  ar(2'd0, 3'd2, 3'd0, 3'd1));       // ADD R2 = 0x55
    put(3,  mi(1'b0, 3'd2, 6'h30));
    put(4,  ar(2'd1, 3'd3, 3'd1, 3'd0));       // SUB R3 = 0x4B
    put(5,  mi(1'b0, 3'd3, 6'h31));
    put(6,  ai(2'd3, 3'd4, 3'd3, 5'd31));      // MOV R4 = 0xF8
    put(7,  ai(2'd0, 3'd4, 3'd0, 5'd16));      // ADD R4,#16 = 0x08
    put(8,  mi(1'b0, 3'd4, 6'h32));
    put(9,  lr(3'd0, 3'd5, 3'd2, 3'd3));       // AND = 0x41
    put(10, mi(1'b0, 3'd5, 6'h33));
    put(11, lr(3'd1, 3'd5, 3'd2, 3'd3));       // OR = 0x5F
    put(12, mi(1'b0, 3'd5, 6'h34));
    put(13, lr(3'd2, 3'd5, 3'd2, 3'd3));       // XOR = 0x1E
    put(14, mi(1'b0, 3'd5, 6'h35));
    put(15, ai(2'd1, 3'd5, 3'd0, 5'd5));       // SUB R5,#5 = 0x19
    put(16, mi(1'b0, 3'd5, 6'h36));
    put(17, ar(2'd2, 3'd0, 3'd0, 3'd0));       // CMP R0,R0
    put(18, br(2'd0, 2'd0, 6'd36));
    expect_wr(6'h30, 8'h55, "R3");
    expect_wr(6'h31, 8'h4B, "R3");
    expect_wr(6'h32, 8'h08, "R3");
    expect_wr(6'h33, 8'h41, "R5");
    expect_wr(6'h34, 8'h5F, "R5");
    expect_wr(6'h35, 8'h1E, "R5");
    expect_wr(6'h36, 8'h19, "R3");
    run_prog(150);
    chk(zf_o && cf_o, "R4", "CMP equal sets Z and C", {zf_o, cf_o}, 3);

    // program B: shifts, stores, loads
    clear_prog();
    put(0,  ai(2'd3, 3'd3, 3'd6, 5'd19));      // MOV R3 = 0xC4
    put(1,  mi(1'b0, 3'd3, 6'h30));
    put(2,  ls(3'd3, 3'd3, 3'd3));             // ROL 3 = 0x26
    put(3,  mi(1'b0, 3'd3, 6'h31));
    put(4,  ls(3'd4, 3'd3, 3'd2));             // ROR 2 = 0x89
    put(5,  mi(1'b0, 3'd3, 6'h32));
    put(6,  ls(3'd7, 3'd3, 3'd3));             // ASR 3 = 0xF1
    put(7,  mi(1'b0, 3'd3, 6'h33));
    put(8,  ls(3'd6, 3'd3, 3'd4));             // LSR 4 = 0x0F
    put(9,  mi(1'b0, 3'd3, 6'h34));
    put(10, ls(3'd5, 3'd3, 3'd5));             // LSL 5 = 0xE0
    put(11, mi(1'b0, 3'd3, 6'h35));
    put(12, ai(2'd3, 3'd0, 3'd0, 5'd5));
    put(13, ai(2'd3, 3'd1, 3'd2, 5'd20));
    put(14, mr(1'b0, 3'd1, 3'd0, 6'h31));      // [5+0x31]=0x36
    put(15, ai(2'd3, 3'd4, 3'd0, 5'd8));
    put(16, mr(1'b0, 3'd0, 3'd4, 6'h3E));      // [8+0x3E] wraps to 0x06
    put(17, mr(1'b1, 3'd6, 3'd0, 6'h31));      // LDR R6 = 0x50
    put(18, mi(1'b1, 3'd5, 6'h30));            // LDR R5 = 0xC4
    put(19, ar(2'd0, 3'd5, 3'd5, 3'd6));       // ADD = 0x14, C
    put(20, mi(1'b0, 3'd5, 6'h37));
    put(21, br(2'd0, 2'd0, 6'd42));
    expect_wr(6'h30, 8'hC4, "R3");
    expect_wr(6'h31, 8'h26, "R6");
    expect_wr(6'h32, 8'h89, "R6");
    expect_wr(6'h33, 8'hF1, "R6");
    expect_wr(6'h34, 8'h0F, "R6");
    expect_wr(6'h35, 8'hE0, "R6");
    expect_wr(6'h36, 8'h50, "R7");
    expect_wr(6'h06, 8'h05, "R7");
    expect_wr(6'h37, 8'h14, "R8");
    run_prog(200);
    chk(!zf_o && cf_o, "R4", "ADD carry out sets C only", {zf_o, cf_o}, 1);

    // program C: branches
    clear_prog();
    put(0,  ai(2'd3, 3'd0, 3'd0, 5'd1));       // MOV R0,#1
    put(1,  ai(2'd2, 3'd0, 3'd0, 5'd1));       // CMP R0,#1 -> Z1 C1
    put(2,  br(2'd3, 2'd1, 6'd46));            // BNE bad (not taken)
    put(3,  br(2'd3, 2'd0, 6'd10));            // BEQ taken
    put(4,  mi(1'b0, 3'd0, 6'h3F));
    put(5,  mi(1'b0, 3'd0, 6'h30));
    put(6,  br(2'd3, 2'd3, 6'd46));            // BCC not taken
    put(7,  br(2'd3, 2'd2, 6'd18));            // BCS taken
    put(8,  mi(1'b0, 3'd0, 6'h3F));
    put(9,  ai(2'd2, 3'd0, 3'd0, 5'd2));       // CMP R0,#2 -> Z0 C0
    put(10, br(2'd3, 2'd2, 6'd46));            // BCS not taken
    put(11, br(2'd3, 2'd0, 6'd46));            // BEQ not taken
    put(12, br(2'd1, 2'd0, 6'd28));            // BL
    put(13, br(2'd0, 2'd0, 6'd46));
    put(14, mi(1'b0, 3'd6, 6'h31));            // store link = 26
    put(15, br(2'd2, 2'd0, 6'h3D));            // BI via [0x3D]
    put(16, br(2'd0, 2'd0, 6'd46));
    put(17, mi(1'b0, 3'd7, 6'h32));            // store R7 = 36
    put(18, br(2'd3, 2'd1, 6'd40));            // BNE taken
    put(19, br(2'd0, 2'd0, 6'd46));
    put(20, br(2'd3, 2'd3, 6'd44));            // BCC taken
    put(21, br(2'd0, 2'd0, 6'd46));
    put(22, br(2'd0, 2'd0, 6'd44));
    put(23, mi(1'b0, 3'd0, 6'h3F));            // trap
    put(24, br(2'd0, 2'd0, 6'd48));
    prog[6'h3D] = 8'd34;
    expect_wr(6'h30, 8'h01, "R11");
    expect_wr(6'h31, 8'h1A, "R9");
    expect_wr(6'h32, 8'h24, "R10");
    run_prog(200);
    chk(!zf_o && !cf_o, "R4", "CMP with borrow clears Z and C", {zf_o, cf_o}, 0);
    chk(pc_o == 8'd44 || pc_o == 8'd46, "R11", "final loop after taken branches", pc_o, 44);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule